// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits behind the host write port of a 16-bit NOR flash device. It sees every host write as one address/data pair on a single-cycle write enable. It recognizes the multi-write command sequences built on the two-write unlock handshake. When a sequence completes, it raises a one-cycle operation strobe with an operation code and the address and data that belong to that operation. The array and its program/erase engines consume these strobes.

The decoder keeps a base mode: read array, autoselect, unlock bypass, erase-suspended, identification query, or aborted buffer load. It also keeps a step register that records how far into the current sequence the host has got. The array engine reports back through two inputs. `busy` shows that any program or erase is running. `eraseRun` shows that a sector erase is the operation in progress. A write that does not fit the expected next step of a sequence returns the step to the start, keeps the base mode, and gives no strobe.

Top module: `flash_cmd_dec`

## Requirements
- R1: While `rstN` is low and after it is released, `opValid` is 0 and `mode` is 0 (read array).
- R2: The unlock pair is data AA at address 555 and then data 55 at address 2AA. Only address bits [11:0] and data bits [7:0] are compared for command writes. Unlock, then A0 at 555, then a fourth write issues `opCode` 3 (program), with `opAddr`/`opData` equal to that fourth write.
- R3: A write of F0 at any address issues `opCode` 1 (reset). It returns the mode to 0, or keeps it at 3 when erase-suspended. This applies at any step except one that captures a data word (program data, bypass program data, word count or buffered word).
- R4: Unlock, 80@555, unlock, 10@555 issues `opCode` 6 (chip erase). Ending the sequence instead with 30 at any address issues `opCode` 7 (sector erase), with `opAddr` set to that address.
- R5: Unlock, then 25 at the sector address, moves `mode` to 4 (buffer loading). The next write holds N-1. Each of the next N writes issues `opCode` 4 with its own address/data. A write of 29 then issues `opCode` 5, with `opAddr` = sector address and `opData` = N-1, and the mode returns to 0.
- R6: The load is aborted, with `mode` 5 and no strobe, if any of these occurs: a buffered word falls outside the page of the first word (page = address bits above log2(BUF_WORDS)); the count is BUF_WORDS or more; or the write after the last word is not 29. In mode 5 every write except F0 is ignored.
- R7: B0 at any address issues `opCode` 8 (suspend) and sets `mode` 3, but only while `eraseRun` is high. In mode 3, 30 at any address issues `opCode` 9 (resume) and sets `mode` 0. Program sequences still work in mode 3.
- R8: Unlock plus 20@555 issues `opCode` 11 and sets `mode` 2. In mode 2, A0 followed by any write issues `opCode` 13 (bypass program). 90 followed by 00 issues `opCode` 12 and sets `mode` 0.
- R9: 98 at 555 issues `opCode` 10 and sets `mode` 6, but only from mode 0 or mode 1. In mode 6 every write except F0 is ignored.
- R10: Unlock plus 90 at 555 (bank bits above ignored) issues `opCode` 2 and sets `mode` 1. In mode 1 only F0 and the query entry have any effect.
- R11: A write that does not fit the next step of a sequence issues no strobe, leaves `mode` unchanged and restarts sequence recognition.
- R12: While `busy` is high, every write other than an accepted suspend is ignored, and the sequence in progress is preserved.
- R13: `opValid` is never high in the cycle after a cycle with `wrEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One host write this cycle |
| wrAddr | input | ADDR_W | Write word address |
| wrData | input | DATA_W | Write data |
| busy | input | 1 | Array engine busy with program or erase |
| eraseRun | input | 1 | A sector erase is in progress |
| opValid | output | 1 | One-cycle operation strobe |
| opCode | output | 4 | Operation code (see requirements) |
| opAddr | output | ADDR_W | Address argument of the operation |
| opData | output | DATA_W | Data argument of the operation |
| mode | output | 3 | Current mode (see requirements) |

## Verification
The hardest situations to reach from the ports are those that depend on earlier writes. A buffer load can be aborted part-way through by a word outside its page, by a count that is too large, or by a wrong confirm. A write made while busy must not disturb an unlock that is only half-complete. The bench drives complete buffer loads whose words sit just inside and just outside a page boundary, and loads with an oversized count and with a wrong confirm. It then shows through `mode` and the strobes that only F0 leads out of the abort. For the busy case, it starts an unlock, makes one write while `busy` is high, and finishes the program afterwards. A program strobe at the end shows the half-complete sequence survived.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_RESET     = 4'd1,
    OP_AUTOSEL   = 4'd2,
    OP_PROGRAM   = 4'd3,
    OP_BUFWORD   = 4'd4,
    OP_BUFCOMMIT = 4'd5,
    OP_CHIPERASE = 4'd6,
    OP_SECTERASE = 4'd7,
    OP_SUSPEND   = 4'd8,
    OP_RESUME    = 4'd9,
    OP_CFI       = 4'd10,
    OP_BYPENTER  = 4'd11,
    OP_BYPEXIT   = 4'd12,
    OP_BYPPROG   = 4'd13
  } opCode_e;

  typedef enum logic [2:0] {
    MODE_READ     = 3'd0,
    MODE_AUTOSEL  = 3'd1,
    MODE_BYPASS   = 3'd2,
    MODE_SUSPEND  = 3'd3,
    MODE_BUFLOAD  = 3'd4,
    MODE_BUFABORT = 3'd5,
    MODE_CFI      = 3'd6
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROGDATA, ST_ERS, ST_ERSUNL1, ST_ERSUNL2,
    ST_BUFCNT, ST_BUFWORD, ST_BUFCOMMIT, ST_BYPDATA, ST_BYPEXIT
  } step_e;

  // Decoded compare results of one host write.
  typedef struct packed {
    logic at555, at2AA;
    logic dAA, d55, dA0, d80, d10, d30, d90, d20, d25, d29, d98, dF0, dB0, d00;
  } cmdMatch_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    fire;
    opCode_e code;
    logic    useSector;
    logic    useCount;
    logic    latchSector;
    logic    loadCount;
    logic    decCount;
    logic    latchPage;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [11:0] addrLow,
  input  logic [7:0]  dataLow,
  output cmdMatch_t   m
);
  always_comb begin
    m.at555 = (addrLow == 12'h555);
    m.at2AA = (addrLow == 12'h2AA);
    m.dAA   = (dataLow == 8'hAA);
    m.d55   = (dataLow == 8'h55);
    m.dA0   = (dataLow == 8'hA0);
    m.d80   = (dataLow == 8'h80);
    m.d10   = (dataLow == 8'h10);
    m.d30   = (dataLow == 8'h30);
    m.d90   = (dataLow == 8'h90);
    m.d20   = (dataLow == 8'h20);
    m.d25   = (dataLow == 8'h25);
    m.d29   = (dataLow == 8'h29);
    m.d98   = (dataLow == 8'h98);
    m.dF0   = (dataLow == 8'hF0);
    m.dB0   = (dataLow == 8'hB0);
    m.d00   = (dataLow == 8'h00);
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        busy,
  input  logic        eraseRun,
  input  cmdMatch_t   m,
  input  logic        countZero,
  input  logic        pageOk,
  input  logic        countBig,
  output ctrlStrobe_t strb,
  output logic [2:0]  mode
);
  step_e stepQ, stepD;
  mode_e baseQ, baseD;
  logic  payload;
  logic  inBuf;

  always_comb begin
    stepD   = stepQ;
    baseD   = baseQ;
    strb    = '0;
    payload = (stepQ == ST_PROGDATA) || (stepQ == ST_BUFCNT) ||
              (stepQ == ST_BUFWORD)  || (stepQ == ST_BYPDATA);
    if (wrEn) begin
      if (eraseRun && m.dB0) begin
        strb.fire = 1'b1; strb.code = OP_SUSPEND;
        baseD = MODE_SUSPEND; stepD = ST_IDLE;
      end else if (busy) begin
        stepD = stepQ;
      end else if (baseQ == MODE_CFI || baseQ == MODE_AUTOSEL || baseQ == MODE_BUFABORT) begin
        if (m.dF0) begin
          strb.fire = 1'b1; strb.code = OP_RESET; baseD = MODE_READ;
        end else if (baseQ == MODE_AUTOSEL && m.d98 && m.at555) begin
          strb.fire = 1'b1; strb.code = OP_CFI; baseD = MODE_CFI;
        end
      end else if (!payload && m.dF0) begin
        strb.fire = 1'b1; strb.code = OP_RESET; stepD = ST_IDLE;
        baseD = (baseQ == MODE_SUSPEND) ? MODE_SUSPEND : MODE_READ;
      end else begin
        stepD = ST_IDLE;
        case (stepQ)
          ST_IDLE: begin
            if (baseQ == MODE_BYPASS) begin
              if (m.dA0)      stepD = ST_BYPDATA;
              else if (m.d90) stepD = ST_BYPEXIT;
            end else if (m.dAA && m.at555) begin
              stepD = ST_UNL1;
            end else if (baseQ == MODE_READ && m.d98 && m.at555) begin
              strb.fire = 1'b1; strb.code = OP_CFI; baseD = MODE_CFI;
            end else if (baseQ == MODE_SUSPEND && m.d30) begin
              strb.fire = 1'b1; strb.code = OP_RESUME; baseD = MODE_READ;
            end
          end
          ST_UNL1: if (m.d55 && m.at2AA) stepD = ST_UNL2;
          ST_UNL2: begin
            if (m.dA0 && m.at555) stepD = ST_PROGDATA;
            else if (baseQ == MODE_READ) begin
              if (m.d80 && m.at555) stepD = ST_ERS;
              else if (m.d90 && m.at555) begin
                strb.fire = 1'b1; strb.code = OP_AUTOSEL; baseD = MODE_AUTOSEL;
              end else if (m.d20 && m.at555) begin
                strb.fire = 1'b1; strb.code = OP_BYPENTER; baseD = MODE_BYPASS;
              end else if (m.d25) begin
                strb.latchSector = 1'b1; stepD = ST_BUFCNT;
              end
            end
          end
          ST_PROGDATA: begin strb.fire = 1'b1; strb.code = OP_PROGRAM; end
          ST_ERS:      if (m.dAA && m.at555) stepD = ST_ERSUNL1;
          ST_ERSUNL1:  if (m.d55 && m.at2AA) stepD = ST_ERSUNL2;
          ST_ERSUNL2: begin
            if (m.d10 && m.at555) begin
              strb.fire = 1'b1; strb.code = OP_CHIPERASE;
            end else if (m.d30) begin
              strb.fire = 1'b1; strb.code = OP_SECTERASE;
            end
          end
          ST_BUFCNT: begin
            if (countBig) baseD = MODE_BUFABORT;
            else begin strb.loadCount = 1'b1; stepD = ST_BUFWORD; end
          end
          ST_BUFWORD: begin
            if (!pageOk) baseD = MODE_BUFABORT;
            else begin
              strb.fire = 1'b1; strb.code = OP_BUFWORD; strb.latchPage = 1'b1;
              if (countZero) stepD = ST_BUFCOMMIT;
              else begin strb.decCount = 1'b1; stepD = ST_BUFWORD; end
            end
          end
          ST_BUFCOMMIT: begin
            if (m.d29) begin
              strb.fire = 1'b1; strb.code = OP_BUFCOMMIT;
              strb.useSector = 1'b1; strb.useCount = 1'b1;
            end else baseD = MODE_BUFABORT;
          end
          ST_BYPDATA: begin strb.fire = 1'b1; strb.code = OP_BYPPROG; end
          ST_BYPEXIT: begin
            if (m.d00) begin
              strb.fire = 1'b1; strb.code = OP_BYPEXIT; baseD = MODE_READ;
            end
          end
          default: stepD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ <= ST_IDLE;
      baseQ <= MODE_READ;
    end else begin
      stepQ <= stepD;
      baseQ <= baseD;
    end
  end

  assign inBuf = (stepQ == ST_BUFCNT) || (stepQ == ST_BUFWORD) || (stepQ == ST_BUFCOMMIT);
  assign mode  = inBuf ? MODE_BUFLOAD : baseQ;
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobe_t       strb,
  output logic              countZero,
  output logic              pageOk,
  output logic              countBig,
  output logic              opValid,
  output logic [3:0]        opCode,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);
  localparam int CNT_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam int PAGE_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] sectorQ;
  logic [CNT_W-1:0]  totalQ, remainQ;
  logic [PAGE_W-1:0] pageQ;
  logic              pageValidQ;
  opCode_e           opCodeQ;

  assign countBig  = (wrData >= DATA_W'(BUF_WORDS));
  assign countZero = (remainQ == '0);
  assign pageOk    = !pageValidQ || (wrAddr[ADDR_W-1:CNT_W] == pageQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid    <= 1'b0;
      opCodeQ    <= OP_NONE;
      opAddr     <= '0;
      opData     <= '0;
      sectorQ    <= '0;
      totalQ     <= '0;
      remainQ    <= '0;
      pageQ      <= '0;
      pageValidQ <= 1'b0;
    end else begin
      opValid <= strb.fire;
      if (strb.fire) begin
        opCodeQ <= strb.code;
        opAddr  <= strb.useSector ? sectorQ : wrAddr;
        opData  <= strb.useCount ? DATA_W'(totalQ) : wrData;
      end
      if (strb.latchSector) sectorQ <= wrAddr;
      if (strb.loadCount) begin
        totalQ     <= wrData[CNT_W-1:0];
        remainQ    <= wrData[CNT_W-1:0];
        pageValidQ <= 1'b0;
      end
      if (strb.decCount) remainQ <= remainQ - 1'b1;
      if (strb.latchPage) begin
        pageQ      <= wrAddr[ADDR_W-1:CNT_W];
        pageValidQ <= 1'b1;
      end
    end
  end

  assign opCode = opCodeQ;
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              eraseRun,
  output logic              opValid,
  output logic [3:0]        opCode,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [2:0]        mode
);
  cmdMatch_t   match;
  ctrlStrobe_t strb;
  logic        countZero, pageOk, countBig;

  flash_cmd_match match_i (
    .addrLow (wrAddr[11:0]),
    .dataLow (wrData[7:0]),
    .m       (match)
  );

  flash_cmd_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .busy      (busy),
    .eraseRun  (eraseRun),
    .m         (match),
    .countZero (countZero),
    .pageOk    (pageOk),
    .countBig  (countBig),
    .strb      (strb),
    .mode      (mode)
  );

  flash_cmd_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BUF_WORDS (BUF_WORDS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strb      (strb),
    .countZero (countZero),
    .pageOk    (pageOk),
    .countBig  (countBig),
    .opValid   (opValid),
    .opCode    (opCode),
    .opAddr    (opAddr),
    .opData    (opData)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       busy,
  input logic       eraseRun,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic [2:0] mode
);
  // R13
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !opValid);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy && !eraseRun) |=> (!opValid && $stable(mode)));

  // R7
  suspend_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SUSPEND) |-> (mode == MODE_SUSPEND));

  // R7
  resume_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_RESUME) |-> ($past(mode) == MODE_SUSPEND));

  // R9
  cfi_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CFI) |->
      ($past(mode) == MODE_READ || $past(mode) == MODE_AUTOSEL));

  // R6
  abort_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BUFABORT) |-> !opValid);

  // R5
  bufword_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_BUFWORD) |-> ($past(mode) == MODE_BUFLOAD));
endmodule

bind flash_cmd_dec flash_cmd_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .busy     (busy),
  .eraseRun (eraseRun),
  .opValid  (opValid),
  .opCode   (opCode),
  .mode     (mode)
);

// File: tb/flash_cmd_dec_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_dec_tb_top;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              busy = 1'b0;
  logic              eraseRun = 1'b0;
  logic              opValid;
  logic [3:0]        opCode;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;
  logic [2:0]        mode;

  int total = 0;
  int bad = 0;

  flash_cmd_dec dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .eraseRun(eraseRun), .opValid(opValid), .opCode(opCode),
    .opAddr(opAddr), .opData(opData), .mode(mode)
  );

  always #10 clk = ~clk;

  // Vector: {addr[23:0], data[15:0], expValid, expCode[3:0], expMode[2:0]}
  localparam int NV = 45;
  localparam logic [47:0] VEC [NV] = '{
    // R2 program, then R2 high address bits ignored in a chip erase (R4)
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h00A0, 1'b0, 4'd0,  3'd0},
    {24'h001234, 16'hBEEF, 1'b1, 4'd3,  3'd0},
    {24'hF12555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h8002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h0080, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h0010, 1'b1, 4'd6,  3'd0},
    // R4 sector erase
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h0080, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h0A4000, 16'h0030, 1'b1, 4'd7,  3'd0},
    // R10 autoselect, R9 query from it, R3 reset out
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h003555, 16'h0090, 1'b1, 4'd2,  3'd1},
    {24'h000555, 16'h00A0, 1'b0, 4'd0,  3'd1},
    {24'h000555, 16'h0098, 1'b1, 4'd10, 3'd6},
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd6},
    {24'h000000, 16'h00F0, 1'b1, 4'd1,  3'd0},
    // R8 bypass enter, program, exit
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h0020, 1'b1, 4'd11, 3'd2},
    {24'h000555, 16'h0077, 1'b0, 4'd0,  3'd2},
    {24'h000000, 16'h00A0, 1'b0, 4'd0,  3'd2},
    {24'h000777, 16'h1234, 1'b1, 4'd13, 3'd2},
    {24'h000000, 16'h0090, 1'b0, 4'd0,  3'd2},
    {24'h000000, 16'h0000, 1'b1, 4'd12, 3'd0},
    // R11 mismatches restart recognition
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h000123, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h00A0, 1'b0, 4'd0,  3'd0},
    // R3 F0 as program data is payload, not a reset
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h00A0, 1'b0, 4'd0,  3'd0},
    {24'h000100, 16'h00F0, 1'b1, 4'd3,  3'd0},
    // R9 query from read array
    {24'h000555, 16'h0098, 1'b1, 4'd10, 3'd6},
    {24'h000000, 16'h00F0, 1'b1, 4'd1,  3'd0},
    // R3 F0 mid-unlock
    {24'h000555, 16'h00AA, 1'b0, 4'd0,  3'd0},
    {24'h0002AA, 16'h0055, 1'b0, 4'd0,  3'd0},
    {24'h000555, 16'h00F0, 1'b1, 4'd1,  3'd0},
    // R7 suspend refused without a running erase
    {24'h000555, 16'h00B0, 1'b0, 4'd0,  3'd0}
  };

  function automatic string reqOf(input int i);
    if (i < 10) return "R2/R4";
    if (i < 16) return "R4";
    if (i < 23) return "R10/R9";
    if (i < 31) return "R8";
    if (i < 35) return "R11";
    if (i < 39) return "R3";
    if (i < 41) return "R9";
    if (i < 44) return "R3";
    return "R7";
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic ev, input logic [3:0] ec, input logic [2:0] em);
    checkVal({tag, " opValid"}, 32'(opValid), 32'(ev));
    if (ev) checkVal({tag, " opCode"}, 32'(opCode), 32'(ec));
    checkVal({tag, " mode"}, 32'(mode), 32'(em));
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1 in reset", 1'b0, 4'd0, 3'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkOut("R1 after reset", 1'b0, 4'd0, 3'd0);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][47:24], VEC[i][23:8]);
      checkOut($sformatf("%s vector %0d", reqOf(i), i), VEC[i][7], VEC[i][6:3], VEC[i][2:0]);
    end

    // R2 arguments and high bits
    doWrite(24'hABC555, 16'h12AA); doWrite(24'h0012AA, 16'h3455);
    doWrite(24'h777555, 16'h00A0); doWrite(24'hFEDCBA, 16'h5A5A);
    checkOut("R2 program", 1'b1, 4'd3, 3'd0);
    checkVal("R2 opAddr", 32'(opAddr), 32'h00FEDCBA);
    checkVal("R2 opData", 32'(opData), 32'h5A5A);

    // R13 idle cycle gives no strobe
    @(posedge clk); #1;
    checkVal("R13 idle", 32'(opValid), 32'd0);

    // R5 buffer load of three words, last one at page edge
    doWrite(24'h000555, 16'h00AA); doWrite(24'h0002AA, 16'h0055);
    doWrite(24'h012340, 16'h0025);
    checkOut("R5 start", 1'b0, 4'd0, 3'd4);
    doWrite(24'h012340, 16'h0002);
    checkOut("R5 count", 1'b0, 4'd0, 3'd4);
    doWrite(24'h012345, 16'h1111);
    checkOut("R5 word0", 1'b1, 4'd4, 3'd4);
    checkVal("R5 word0 addr", 32'(opAddr), 32'h012345);
    checkVal("R5 word0 data", 32'(opData), 32'h1111);
    doWrite(24'h012346, 16'h2222);
    checkOut("R5 word1", 1'b1, 4'd4, 3'd4);
    doWrite(24'h01235F, 16'h3333);
    checkOut("R5 word2", 1'b1, 4'd4, 3'd4);
    doWrite(24'h012340, 16'h0029);
    checkOut("R5 commit", 1'b1, 4'd5, 3'd0);
    checkVal("R5 commit addr", 32'(opAddr), 32'h012340);
    checkVal("R5 commit count", 32'(opData), 32'd2);

    // R6 page violation
    doWrite(24'h000555, 16'h00AA); doWrite(24'h0002AA, 16'h0055);
    doWrite(24'h012340, 16'h0025); doWrite(24'h012340, 16'h0003);
    doWrite(24'h012345, 16'h1111);
    doWrite(24'h012365, 16'h2222);
    checkOut("R6 page abort", 1'b0, 4'd0, 3'd5);
    doWrite(24'h000555, 16'h00AA);
    checkOut("R6 ignored in abort", 1'b0, 4'd0, 3'd5);
    doWrite(24'h000000, 16'h00F0);
    checkOut("R6 leave abort", 1'b1, 4'd1, 3'd0);

    // R6 count too large
    doWrite(24'h000555, 16'h00AA); doWrite(24'h0002AA, 16'h0055);
    doWrite(24'h012340, 16'h0025); doWrite(24'h012340, 16'h0020);
    checkOut("R6 big count", 1'b0, 4'd0, 3'd5);
    doWrite(24'h000000, 16'h00F0);
    checkOut("R6 leave abort 2", 1'b1, 4'd1, 3'd0);

    // R6 wrong confirm
    doWrite(24'h000555, 16'h00AA); doWrite(24'h0002AA, 16'h0055);
    doWrite(24'h012340, 16'h0025); doWrite(24'h012340, 16'h0000);
    doWrite(24'h012341, 16'h4444);
    doWrite(24'h012340, 16'h0030);
    checkOut("R6 bad confirm", 1'b0, 4'd0, 3'd5);
    doWrite(24'h000000, 16'h00F0);
    checkOut("R6 leave abort 3", 1'b1, 4'd1, 3'd0);

    // R12 busy write preserves a half-finished unlock
    doWrite(24'h000555, 16'h00AA); doWrite(24'h0002AA, 16'h0055);
    busy = 1'b1;
    doWrite(24'h000555, 16'h0080);
    checkOut("R12 busy ignored", 1'b0, 4'd0, 3'd0);
    doWrite(24'h000000, 16'h00B0);
    checkOut("R12 suspend needs erase", 1'b0, 4'd0, 3'd0);
    busy = 1'b0;
    doWrite(24'h000555, 16'h00A0); doWrite(24'h000042, 16'h0077);
    checkOut("R12 sequence kept", 1'b1, 4'd3, 3'd0);

    // R7 suspend, program while suspended, reset keeps suspend, resume
    busy = 1'b1; eraseRun = 1'b1;
    doWrite(24'h0A0000, 16'h00B0);
    checkOut("R7 suspend", 1'b1, 4'd8, 3'd3);
    busy = 1'b0; eraseRun = 1'b0;
    doWrite(24'h000555, 16'h00AA); doWrite(24'h0002AA, 16'h0055);
    doWrite(24'h000555, 16'h00A0); doWrite(24'h000900, 16'h0101);
    checkOut("R7 program in suspend", 1'b1, 4'd3, 3'd3);
    doWrite(24'h000000, 16'h00F0);
    checkOut("R3 reset in suspend", 1'b1, 4'd1, 3'd3);
    doWrite(24'h000555, 16'h0098);
    checkOut("R9 no query in suspend", 1'b0, 4'd0, 3'd3);
    doWrite(24'h0A0000, 16'h0030);
    checkOut("R7 resume", 1'b1, 4'd9, 3'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule